// File: doc/BRIEF.md
# Programmable-Timing Asynchronous SRAM Controller

This block turns single read or write requests from a simple internal request/response port into one asynchronous memory cycle on the chip-select, address, address-valid (ADV), output-enable, write-enable and data pins. Every phase of the cycle lasts a programmed number of clock cycles, so one netlist can serve fast and slow parts at any clock rate. The values come from a packed timing vector that software fills in.

Two pin modes are offered. In multiplexed mode the address and the data share the data pins, and ADV marks the address phase. In bus mode writes keep the address and the data on separate pins, while reads still run as multiplexed cycles. The data bus is 8 or 16 bits wide. A programmable base and a power-of-two size set the window the block answers. Any other request gets an error response, and the pins stay quiet.

Top module: `sramTimingCtrl`

## Requirements
- R1: A request is served only if its address has bits [31:29] equal to 3'b100, so that it lies between 0x80000000 and 0x9FFFFFFF, and if `(addr & ~(cfgSize-1)) == cfgBase`. Any other request gets `rspValid` with `rspErr`=1 in the cycle after acceptance, and `memCsN` never falls for it.
- R2: If `cfgSize` is zero or not a power of two, or if `cfgBase` is not a multiple of `cfgSize`, every request gets an error response.
- R3: `cfgTiming` holds eleven fields of TW bits, with field k at bits [k*TW+TW-1:k*TW]. In order from k=0 they are: chip-select setup, chip-select hold, address setup, address hold, write strobe low, write strobe high, read strobe low, read strobe high, address-after-write hold, turnaround and chip-select gap. A field value v gives a phase of v+1 cycles.
- R4: A write holds `memCsN` low for exactly the sum of (field+1) over chip-select setup, address setup, address hold, write strobe low, write strobe high, address-after-write hold and chip-select hold. `memWeN` is low for exactly (write strobe low)+1 cycles.
- R5: During every cycle in which `memWeN` is low, `memDataOe`=1 and `memDataOut` carries the write data.
- R6: A read holds `memCsN` low for the sum of (field+1) over chip-select setup, address setup, address hold, read strobe low, read strobe high and chip-select hold. `memOeN` is low for exactly (read strobe low)+1 cycles. `rspRdata` is the value on `memDataIn` in the last cycle of the read-strobe-low phase.
- R7: A multiplexed access holds `memAdv` at `cfgAdvPol` for exactly (address setup)+1 cycles and drives the word address[15:0] on the data pins during address setup and address hold. From the end of address setup until the chip select ends, `memAdv` sits at `cfgAdvHold`. Outside a multiplexed access `memAdv` = ~`cfgAdvPol`.
- R8: With `cfgMuxMode`=0 (bus mode), a write never activates `memAdv` and places its address only on `memAddr`. A read runs as a multiplexed cycle whatever `cfgMuxMode` holds.
- R9: With `cfgWide`=1 the word address is offset>>1 and all 16 data bits are used. With `cfgWide`=0 the word address is the offset, write data bits [15:8] are driven as 0, and read data is zero-extended from `memDataIn[7:0]`. Here offset = addr & (cfgSize-1).
- R10: Between two served accesses `memCsN` stays high for at least (chip-select gap)+1 cycles. After a read it stays high for at least max(gap, turnaround)+1 cycles.
- R11: `rspValid` is a one-cycle pulse. `reqReady` is low from the cycle after acceptance until the response has been given.
- R12: The block never drives the data pins while `memOeN` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 32 | Byte address of the request |
| reqWdata | input | 16 | Write data |
| reqReady | output | 1 | Block can accept a request |
| rspValid | output | 1 | One-cycle response strobe |
| rspErr | output | 1 | Response is an address error |
| rspRdata | output | 16 | Read data of the last read |
| cfgMuxMode | input | 1 | 1 = multiplexed, 0 = bus mode |
| cfgWide | input | 1 | 1 = 16-bit, 0 = 8-bit data bus |
| cfgAdvPol | input | 1 | Active level of ADV |
| cfgAdvHold | input | 1 | ADV level after the address phase |
| cfgBase | input | 32 | Region base address |
| cfgSize | input | 32 | Region size in bytes |
| cfgTiming | input | 11*TW | Packed phase lengths, minus one |
| memCsN | output | 1 | Chip select, active low |
| memAdv | output | 1 | Address valid |
| memOeN | output | 1 | Output enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memAddr | output | ADDR_W | Word address |
| memDataOut | output | 16 | Data pins, outgoing value |
| memDataOe | output | 1 | Data pins driven |
| memDataIn | input | 16 | Data pins, incoming value |

## Verification
An error response arrives in the cycle after acceptance. A served access answers in the cycle after chip select rises, which is one cycle after the last chip-select-hold cycle. The bench therefore waits for `rspValid` at falling edges and reads the pin monitors a quarter period later, after they have recorded the rising chip select. The memory model gives the correct read word only in the cycle where the capture is due, `oeLo`+1 falling edges into the strobe, so a capture one cycle early or late returns the inverted word. Phase widths, the ADV window and the chip-select gaps are counted at falling edges and compared with sums computed from the random fields.

// File: rtl/sramCtrlPkg.sv
package sramCtrlPkg;
  localparam int F_CS_SETUP     = 0;
  localparam int F_CS_HOLD      = 1;
  localparam int F_ADDR_SETUP   = 2;
  localparam int F_ADDR_HOLD    = 3;
  localparam int F_WE_LO        = 4;
  localparam int F_WE_HI        = 5;
  localparam int F_OE_LO        = 6;
  localparam int F_OE_HI        = 7;
  localparam int F_ADDR_WR_HOLD = 8;
  localparam int F_TURN         = 9;
  localparam int F_CS_GAP       = 10;
  localparam int NUM_FIELDS     = 11;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CS_SETUP, ST_ADDR_SETUP, ST_ADDR_HOLD, ST_WE_LO, ST_WE_HI,
    ST_ADDR_WR_HOLD, ST_OE_LO, ST_OE_HI, ST_CS_HOLD, ST_RESP
  } phase_t;

  typedef struct packed {
    logic load;        // latch request into datapath
    logic csOn;        // chip select active
    logic advOn;       // multiplexed address phase
    logic advRest;     // multiplexed access after address phase
    logic addrOnData;  // address placed on data pins
    logic weOn;        // write strobe low
    logic wdOn;        // write data driven
    logic oeOn;        // read strobe low
    logic capture;     // sample read data
  } strobe_t;
endpackage

// File: rtl/sramCtrlFsm.sv
module sramCtrlFsm
  import sramCtrlPkg::*;
#(
  parameter int TW = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  input  logic                     reqWrite,
  input  logic                     hit,
  input  logic                     cfgMuxMode,
  input  logic [NUM_FIELDS*TW-1:0] cfgTiming,
  output logic                     reqReady,
  output logic                     rspValid,
  output logic                     rspErr,
  output strobe_t                  strobes
);
  logic [TW-1:0] fld [NUM_FIELDS];
  for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_unpack
    assign fld[k] = cfgTiming[k*TW +: TW];
  end

  phase_t        state, nextPhase;
  logic [TW-1:0] cnt, nextLen, gapCnt, gapLoad;
  logic          isWrite, errFlag, accept, muxAccess;

  assign reqReady  = (state == ST_IDLE) && (gapCnt == '0);
  assign accept    = reqReady && reqValid;
  assign muxAccess = cfgMuxMode || !isWrite;
  assign gapLoad   = (!isWrite && (fld[F_TURN] > fld[F_CS_GAP])) ? fld[F_TURN] : fld[F_CS_GAP];

  always_comb begin
    case (state)
      ST_CS_SETUP:     nextPhase = ST_ADDR_SETUP;
      ST_ADDR_SETUP:   nextPhase = ST_ADDR_HOLD;
      ST_ADDR_HOLD:    nextPhase = isWrite ? ST_WE_LO : ST_OE_LO;
      ST_WE_LO:        nextPhase = ST_WE_HI;
      ST_WE_HI:        nextPhase = ST_ADDR_WR_HOLD;
      ST_ADDR_WR_HOLD: nextPhase = ST_CS_HOLD;
      ST_OE_LO:        nextPhase = ST_OE_HI;
      ST_OE_HI:        nextPhase = ST_CS_HOLD;
      ST_CS_HOLD:      nextPhase = ST_RESP;
      default:         nextPhase = ST_IDLE;
    endcase
    case (nextPhase)
      ST_ADDR_SETUP:   nextLen = fld[F_ADDR_SETUP];
      ST_ADDR_HOLD:    nextLen = fld[F_ADDR_HOLD];
      ST_WE_LO:        nextLen = fld[F_WE_LO];
      ST_WE_HI:        nextLen = fld[F_WE_HI];
      ST_ADDR_WR_HOLD: nextLen = fld[F_ADDR_WR_HOLD];
      ST_OE_LO:        nextLen = fld[F_OE_LO];
      ST_OE_HI:        nextLen = fld[F_OE_HI];
      ST_CS_HOLD:      nextLen = fld[F_CS_HOLD];
      default:         nextLen = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      gapCnt  <= '0;
      isWrite <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      if (gapCnt != '0) gapCnt <= gapCnt - 1'b1;
      case (state)
        ST_IDLE: if (accept) begin
          isWrite <= reqWrite;
          errFlag <= !hit;
          state   <= hit ? ST_CS_SETUP : ST_RESP;
          cnt     <= fld[F_CS_SETUP];
        end
        ST_RESP: state <= ST_IDLE;
        default: if (cnt == '0) begin
          state <= nextPhase;
          cnt   <= nextLen;
          if (state == ST_CS_HOLD) gapCnt <= gapLoad;
        end else begin
          cnt <= cnt - 1'b1;
        end
      endcase
    end
  end

  assign rspValid = (state == ST_RESP);
  assign rspErr   = (state == ST_RESP) && errFlag;

  always_comb begin
    strobes            = '0;
    strobes.load       = accept;
    strobes.csOn       = (state != ST_IDLE) && (state != ST_RESP);
    strobes.advOn      = muxAccess && (state == ST_ADDR_SETUP);
    strobes.advRest    = muxAccess && strobes.csOn &&
                         (state != ST_CS_SETUP) && (state != ST_ADDR_SETUP);
    strobes.addrOnData = muxAccess && ((state == ST_ADDR_SETUP) || (state == ST_ADDR_HOLD));
    strobes.weOn       = (state == ST_WE_LO);
    strobes.wdOn       = (state == ST_WE_LO) || (state == ST_WE_HI);
    strobes.oeOn       = (state == ST_OE_LO);
    strobes.capture    = (state == ST_OE_LO) && (cnt == '0);
  end

  // R1: a miss answers with an error in the next cycle
  p_miss_errs_r1: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !hit) |=> (rspValid && rspErr));
  // R11: a hit starts a chip select and no response yet
  p_hit_starts_r11: assert property (@(posedge clk) disable iff (!rstN)
    (accept && hit) |=> (strobes.csOn && !rspValid && !reqReady));
  // R11: response lasts one cycle
  p_rsp_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);
endmodule

// File: rtl/sramCtrlDatapath.sv
module sramCtrlDatapath
  import sramCtrlPkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [31:0]       reqAddr,
  input  logic [15:0]       reqWdata,
  input  logic              cfgWide,
  input  logic              cfgAdvPol,
  input  logic              cfgAdvHold,
  input  logic [31:0]       cfgBase,
  input  logic [31:0]       cfgSize,
  input  logic [15:0]       memDataIn,
  output logic              hit,
  output logic              memCsN,
  output logic              memAdv,
  output logic              memOeN,
  output logic              memWeN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [15:0]       memDataOut,
  output logic              memDataOe,
  output logic [15:0]       rspRdata
);
  logic [31:0]       sizeMask, offset, wordWide;
  logic              sizeOk, alignOk, windowOk, regionOk;
  logic [ADDR_W-1:0] wordAddr;
  logic [15:0]       wdataQ;

  assign sizeMask = cfgSize - 32'd1;
  assign sizeOk   = (cfgSize != '0) && ((cfgSize & sizeMask) == '0);
  assign alignOk  = (cfgBase & sizeMask) == '0;
  assign windowOk = reqAddr[31:29] == 3'b100;
  assign regionOk = (reqAddr & ~sizeMask) == cfgBase;
  assign hit      = sizeOk && alignOk && windowOk && regionOk;
  assign offset   = reqAddr & sizeMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordAddr <= '0;
      wdataQ   <= '0;
      rspRdata <= '0;
    end else begin
      if (strobes.load) begin
        wordAddr <= cfgWide ? offset[ADDR_W:1] : offset[ADDR_W-1:0];
        wdataQ   <= cfgWide ? reqWdata : {8'h00, reqWdata[7:0]};
      end
      if (strobes.capture)
        rspRdata <= cfgWide ? memDataIn : {8'h00, memDataIn[7:0]};
    end
  end

  assign wordWide   = 32'(wordAddr);
  assign memCsN     = !strobes.csOn;
  assign memWeN     = !strobes.weOn;
  assign memOeN     = !strobes.oeOn;
  assign memAdv     = strobes.advOn   ? cfgAdvPol  :
                      strobes.advRest ? cfgAdvHold : !cfgAdvPol;
  assign memAddr    = strobes.csOn ? wordAddr : '0;
  assign memDataOe  = strobes.addrOnData || strobes.wdOn;
  assign memDataOut = strobes.addrOnData ? wordWide[15:0] :
                      strobes.wdOn       ? wdataQ         : 16'h0000;

  // R12: no drive while the memory drives
  p_no_drive_oe_r12: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> !memDataOe);
  // R5: write data present throughout strobe low
  p_we_data_r5: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (memDataOe && !memCsN));
  // R7: address steady inside one chip select
  p_addr_steady_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!memCsN && $past(!memCsN)) |-> $stable(memAddr));
endmodule

// File: rtl/sramTimingCtrl.sv
module sramTimingCtrl
  import sramCtrlPkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int TW     = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  input  logic                     reqWrite,
  input  logic [31:0]              reqAddr,
  input  logic [15:0]              reqWdata,
  output logic                     reqReady,
  output logic                     rspValid,
  output logic                     rspErr,
  output logic [15:0]              rspRdata,
  input  logic                     cfgMuxMode,
  input  logic                     cfgWide,
  input  logic                     cfgAdvPol,
  input  logic                     cfgAdvHold,
  input  logic [31:0]              cfgBase,
  input  logic [31:0]              cfgSize,
  input  logic [NUM_FIELDS*TW-1:0] cfgTiming,
  output logic                     memCsN,
  output logic                     memAdv,
  output logic                     memOeN,
  output logic                     memWeN,
  output logic [ADDR_W-1:0]        memAddr,
  output logic [15:0]              memDataOut,
  output logic                     memDataOe,
  input  logic [15:0]              memDataIn
);
  strobe_t strobes;
  logic    hit;

  sramCtrlFsm #(.TW(TW)) uFsm (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .hit(hit), .cfgMuxMode(cfgMuxMode), .cfgTiming(cfgTiming),
    .reqReady(reqReady), .rspValid(rspValid), .rspErr(rspErr), .strobes(strobes)
  );

  sramCtrlDatapath #(.ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .cfgWide(cfgWide), .cfgAdvPol(cfgAdvPol),
    .cfgAdvHold(cfgAdvHold), .cfgBase(cfgBase), .cfgSize(cfgSize),
    .memDataIn(memDataIn), .hit(hit), .memCsN(memCsN), .memAdv(memAdv),
    .memOeN(memOeN), .memWeN(memWeN), .memAddr(memAddr),
    .memDataOut(memDataOut), .memDataOe(memDataOe), .rspRdata(rspRdata)
  );
endmodule

// File: tb/sim_sramTimingCtrl.sv
module sim_sramTimingCtrl;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 20;
  localparam int TW = 4;
  localparam int NF = 11;

  logic clk = 0, rstN = 0;
  logic reqValid = 0, reqWrite = 0;
  logic [31:0] reqAddr = 0;
  logic [15:0] reqWdata = 0;
  logic reqReady, rspValid, rspErr;
  logic [15:0] rspRdata;
  logic cfgMuxMode = 0, cfgWide = 1, cfgAdvPol = 0, cfgAdvHold = 1;
  logic [31:0] cfgBase = 32'h8000_0000, cfgSize = 32'h0000_1000;
  logic [NF*TW-1:0] cfgTiming = '0;
  logic memCsN, memAdv, memOeN, memWeN, memDataOe;
  logic [ADDR_W-1:0] memAddr;
  logic [15:0] memDataOut, memDataIn;

  int vectors = 0, miscompares = 0;
  int tm [NF];

  always #(CLK_PERIOD/2) clk = ~clk;

  sramTimingCtrl #(.ADDR_W(ADDR_W), .TW(TW)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .rspValid(rspValid), .rspErr(rspErr), .rspRdata(rspRdata),
    .cfgMuxMode(cfgMuxMode), .cfgWide(cfgWide), .cfgAdvPol(cfgAdvPol),
    .cfgAdvHold(cfgAdvHold), .cfgBase(cfgBase), .cfgSize(cfgSize),
    .cfgTiming(cfgTiming), .memCsN(memCsN), .memAdv(memAdv), .memOeN(memOeN),
    .memWeN(memWeN), .memAddr(memAddr), .memDataOut(memDataOut),
    .memDataOe(memDataOe), .memDataIn(memDataIn)
  );

  // ---------------- pin monitor and memory model ----------------
  logic prevCsN = 1;
  int csRun = 0, csHighRun = 0, lastCsLow = 0, gapSeen = 0, csFalls = 0;
  int weCnt = 0, oeCnt = 0, advCount = 0;
  logic [15:0] latchedData = 0, weDataSeen = 0;
  logic [ADDR_W-1:0] weAddrSeen = 0;
  logic weOeSeen = 0, advAtStrobe = 0, oeDriveErr = 0;
  logic advAct;

  function automatic logic [15:0] memWord(input logic [15:0] a);
    return {a[7:0] ^ 8'hA5, a[15:8] + 8'h3C};
  endfunction

  assign advAct    = (memAdv == cfgAdvPol) && !memCsN;
  assign memDataIn = (!memOeN && oeCnt == tm[6] + 1) ? memWord(latchedData) : ~memWord(latchedData);

  always @(negedge clk) begin
    if (!rstN) begin
      prevCsN <= 1; csRun <= 0; csHighRun <= 0; csFalls <= 0;
    end else begin
      if (!memCsN) begin
        csHighRun <= 0;
        if (prevCsN) begin
          gapSeen <= csHighRun; csFalls <= csFalls + 1; csRun <= 1;
          weCnt <= 0; oeCnt <= 0; advCount <= advAct ? 1 : 0; oeDriveErr <= 0;
        end else begin
          csRun <= csRun + 1;
          if (!memWeN) weCnt <= weCnt + 1;
          if (!memOeN) oeCnt <= oeCnt + 1;
          if (advAct) advCount <= advCount + 1;
        end
        if (advAct && memDataOe && memWeN && weCnt == 0) latchedData <= memDataOut;
        if (!memWeN) begin weDataSeen <= memDataOut; weOeSeen <= memDataOe; weAddrSeen <= memAddr; end
        if (!memWeN || !memOeN) advAtStrobe <= memAdv;
        if (!memOeN && memDataOe) oeDriveErr <= 1;
      end else begin
        if (!prevCsN) lastCsLow <= csRun;
        csHighRun <= csHighRun + 1;
      end
      prevCsN <= memCsN;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [NF*TW-1:0] packTiming();
    logic [NF*TW-1:0] v = '0;
    for (int k = 0; k < NF; k++) v[k*TW +: TW] = tm[k][TW-1:0];
    return v;
  endfunction

  function automatic bit expHit(input logic [31:0] a);
    logic [31:0] m = cfgSize - 1;
    if (cfgSize == 0 || (cfgSize & m) != 0 || (cfgBase & m) != 0) return 0;
    if (a < 32'h8000_0000 || a >= 32'hA000_0000) return 0;
    return (a & ~m) == cfgBase;
  endfunction

  function automatic logic [31:0] expWord(input logic [31:0] a);
    logic [31:0] off = a & (cfgSize - 1);
    return cfgWide ? (off >> 1) : off;
  endfunction

  bit havePrev = 0;
  int prevGap = 0;

  task automatic runAccess(input bit wr, input logic [31:0] addr, input logic [15:0] wd);
    bit hitE;
    logic [31:0] word;
    logic [15:0] expData;
    int falls0, expCs, expAdv;
    hitE = expHit(addr);
    word = expWord(addr);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    falls0 = csFalls;
    reqValid = 1; reqWrite = wr; reqAddr = addr; reqWdata = wd;
    @(negedge clk);
    reqValid = 0;
    chk(!reqReady, "R11 ready low after accept", {31'd0, reqReady}, 0);
    while (!rspValid) @(negedge clk);
    chk(rspErr == !hitE, hitE ? "R1 served access flagged" : "R1/R2 miss not flagged", {31'd0, rspErr}, {31'd0, !hitE});
    #(CLK_PERIOD/4);
    if (!hitE) begin
      chk(csFalls == falls0, "R1 chip select on miss", csFalls, falls0);
      return;
    end
    if (havePrev) chk(gapSeen >= prevGap + 1, "R10 chip-select gap", gapSeen, prevGap + 1);
    havePrev = 1;
    expAdv = tm[2] + 1;
    if (wr) begin
      expCs = tm[0] + tm[2] + tm[3] + tm[4] + tm[5] + tm[8] + tm[1] + 7;
      expData = cfgWide ? wd : {8'h00, wd[7:0]};
      chk(lastCsLow == expCs, "R4 write chip-select length", lastCsLow, expCs);
      chk(weCnt == tm[4] + 1, "R4 write strobe width", weCnt, tm[4] + 1);
      chk(weOeSeen && weDataSeen == expData, "R5/R9 write data on pins", {15'd0, weOeSeen, weDataSeen}, {16'h1, expData});
      chk(32'(weAddrSeen) == word, "R9 word address", 32'(weAddrSeen), word);
      if (cfgMuxMode) begin
        chk(latchedData == word[15:0], "R7 address on data pins", latchedData, word[15:0]);
        if (cfgAdvHold != cfgAdvPol) chk(advCount == expAdv, "R7 ADV width", advCount, expAdv);
        chk(advAtStrobe == cfgAdvHold, "R7 ADV rest level", advAtStrobe, cfgAdvHold);
      end else begin
        chk(advCount == 0, "R8 bus write uses no ADV", advCount, 0);
      end
      prevGap = tm[10];
    end else begin
      expCs = tm[0] + tm[2] + tm[3] + tm[6] + tm[7] + tm[1] + 6;
      expData = memWord(word[15:0]);
      if (!cfgWide) expData = {8'h00, expData[7:0]};
      chk(lastCsLow == expCs, "R6 read chip-select length", lastCsLow, expCs);
      chk(oeCnt == tm[6] + 1, "R6 read strobe width", oeCnt, tm[6] + 1);
      chk(rspRdata == expData, "R6/R9 read data", rspRdata, expData);
      chk(latchedData == word[15:0], "R8 read uses multiplexed address", latchedData, word[15:0]);
      if (cfgAdvHold != cfgAdvPol) chk(advCount == expAdv, "R7 ADV width on read", advCount, expAdv);
      chk(advAtStrobe == cfgAdvHold, "R7 ADV rest level on read", advAtStrobe, cfgAdvHold);
      chk(!oeDriveErr, "R12 bus driven during read strobe", {31'd0, oeDriveErr}, 0);
      prevGap = (tm[9] > tm[10]) ? tm[9] : tm[10];
    end
  endtask

  task automatic randomConfig();
    int lg;
    for (int k = 0; k < NF; k++) tm[k] = $urandom_range(0, 5);
    cfgTiming  = packTiming();
    cfgMuxMode = $urandom_range(0, 1);
    cfgWide    = $urandom_range(0, 1);
    cfgAdvPol  = $urandom_range(0, 1);
    cfgAdvHold = $urandom_range(0, 1);
    lg         = $urandom_range(8, 16);
    cfgSize    = 32'd1 << lg;
    cfgBase    = 32'h8000_0000 + $urandom_range(0, 15) * cfgSize;
  endtask

  task automatic randomAccess();
    logic [31:0] a;
    int sel = $urandom_range(0, 9);
    if (sel < 8) a = cfgBase + ($urandom & (cfgSize - 1));
    else if (sel == 8) a = cfgBase + cfgSize + ($urandom & (cfgSize - 1));
    else a = $urandom;
    runAccess($urandom_range(0, 1), a, 16'($urandom));
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    void'($urandom(32'd2024));
    for (int k = 0; k < NF; k++) tm[k] = 0;
    cfgTiming = packTiming();
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(memCsN && memWeN && memOeN && !memDataOe, "R11 reset pins idle", {28'd0, memCsN, memWeN, memOeN, memDataOe}, 32'hE);
    chk(reqReady && !rspValid, "R11 reset handshake", {30'd0, reqReady, rspValid}, 2);

    // R3: all-zero fields give single-cycle phases, both modes and widths
    cfgMuxMode = 1; cfgWide = 1; cfgAdvPol = 1; cfgAdvHold = 0;
    runAccess(1, 32'h8000_0124, 16'hBEEF);
    runAccess(0, 32'h8000_0124, 16'h0000);
    cfgMuxMode = 0; cfgWide = 0;
    runAccess(1, 32'h8000_0FFF, 16'h1234);
    runAccess(0, 32'h8000_0003, 16'h0000);

    // R3: maximum field value, R10 turnaround longer than gap
    for (int k = 0; k < NF; k++) tm[k] = 2;
    tm[6] = 15; tm[4] = 15; tm[9] = 12; tm[10] = 1;
    cfgTiming = packTiming();
    runAccess(0, 32'h8000_0010, 16'h0);
    runAccess(1, 32'h8000_0010, 16'h5A5A);

    // R1: outside the window, edges of the window, neighbour region
    cfgBase = 32'h9FFF_0000; cfgSize = 32'h0001_0000;
    runAccess(0, 32'h9FFF_FFFE, 16'h0);
    runAccess(0, 32'hA000_0000, 16'h0);
    runAccess(1, 32'h7FFF_FFFF, 16'h0);
    cfgBase = 32'h0000_0000; cfgSize = 32'h100;
    runAccess(0, 32'h0000_0010, 16'h0);

    // R2: bad size, misaligned base
    cfgBase = 32'h8000_0000; cfgSize = 32'h0000_0300;
    runAccess(0, 32'h8000_0010, 16'h0);
    cfgBase = 32'h8000_0080; cfgSize = 32'h0000_0100;
    runAccess(1, 32'h8000_0090, 16'h0);
    cfgSize = 0;
    runAccess(0, 32'h8000_0000, 16'h0);

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      if (n % 20 == 0) begin
        @(negedge clk);
        while (!reqReady) @(negedge clk);
        randomConfig();
        havePrev = 0;
      end
      randomAccess();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule